// File: doc/BRIEF.md
# Seconds Watchdog with Event Reload

This block is a countdown watchdog for a system-support chip. Software programs a 16-bit timeout, a time unit and a set of reset actions through a small byte-wide configuration port. The counter then runs down once per second, or once per minute, from a prescaled tick. Software does not kick it through a dedicated register. Instead, side effects of ordinary peripheral traffic reload it: a game-port access, a keyboard or mouse interrupt, or a write to the infrared controller's data register. Each event class has its own enable bit, so the system can pick whichever peripheral activity should prove it is still alive.

When the count reaches zero, a sticky expiry flag is set and the counter stops. The block then fires whichever reset actions are enabled, each as a one-cycle pulse: a keyboard-controller reset and a power-good drop. A timeout interrupt can also be raised, on a line number chosen in the configuration register. The counter stays idle until software writes the timeout again. Infrared reloads are applied a fixed number of cycles after the triggering write, because that controller needs settling time.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, every register reads 0x00, `kbd_rst_o`, `pg_drop_o` and `irq_o` are low, and the counter is idle.
- R2: Register map: control at 0x71, config at 0x72, timeout low byte at 0x73 and high byte at 0x74. Config and timeout read back as written. Control reads back bits 7:4 as written and bit 0 as the expiry flag; bits 3:1 read 0.
- R3: A write to either timeout byte that leaves the 16-bit timeout V nonzero (re)starts the counter. In seconds mode (config bit 7 = 1) the expiry flag is set V*TICKS_PER_SEC cycles after that write's clock edge, and not one cycle earlier.
- R4: With config bit 7 = 0, each count step lasts 60 seconds, so expiry comes V*60*TICKS_PER_SEC cycles after the write.
- R5: On expiry, control bit 0 is set and stays set, and the counter stops.
- R6: At expiry, `kbd_rst_o` pulses high for exactly one cycle if config bit 6 is 1. `pg_drop_o` does the same if config bit 4 is 1. A disabled output stays low.
- R7: `irq_o` is high while the expiry flag is set and config bit 5 is 1. `irq_sel_o` equals config bits 3:0.
- R8: A pulse on `ev_game`, `ev_kbd` or `ev_mouse` reloads a running counter with V when control bit 4, 5 or 6 respectively is set. A pulse whose enable bit is clear has no effect.
- R9: A pulse on `ev_ir` with control bit 7 set reloads the counter exactly IR_DELAY_CYC cycles after the pulse.
- R10: Writing control with bit 1 set forces an immediate expiry, with the same flag and pulses as R5 and R6. Bit 1 reads back 0.
- R11: The expiry flag is cleared by a control write with bit 0 = 1, or by a control write of 0x00. A nonzero control write with bit 0 = 0 leaves it set.
- R12: A timeout byte write that makes V zero stops the counter without expiry. Writing a new nonzero V while the counter runs restarts the count from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ev_ir | input | 1 | Infrared data-register write pulse |
| ev_mouse | input | 1 | Mouse interrupt pulse |
| ev_kbd | input | 1 | Keyboard interrupt pulse |
| ev_game | input | 1 | Game-port access pulse |
| kbd_rst_o | output | 1 | Keyboard-controller reset pulse |
| pg_drop_o | output | 1 | Power-good drop pulse |
| irq_o | output | 1 | Timeout interrupt |
| irq_sel_o | output | 4 | Selected interrupt line |

## Verification
The bench samples the expiry flag one cycle before and exactly at the computed expiry edge. A prescaler that is off by one, or a minutes mode that miscounts, therefore shows up as a flag that appears early or late. Event reloads are sent late in the count, so an ignored enable or an IR delay that is missing or misapplied moves the expiry by a measurable number of cycles. The remaining checks cover these cases:
- A force or clear write that decodes the wrong bit leaves the flag in the wrong state.
- A zero write that fails to stop the counter makes it expire when it should not.
- Reset pulses that stretch or that ignore their enables show up at the ports.

// File: rtl/swd_pkg.sv
package swd_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] A_CTRL = 8'h71;
   localparam logic [BYTE_W-1:0] A_CFG  = 8'h72;
   localparam logic [BYTE_W-1:0] A_VLO  = 8'h73;
   localparam logic [BYTE_W-1:0] A_VHI  = 8'h74;
   // control bit positions
   localparam int C_FORCE = 1;
   localparam int C_STAT  = 0;
   localparam int C_EN_LO = 4;
   // config bit positions
   localparam int F_SEC  = 7;
   localparam int F_KRST = 6;
   localparam int F_IRQ  = 5;
   localparam int F_PG   = 4;
   // event enables, ordered as control bits 7..4
   typedef struct packed {
      logic ir;
      logic mouse;
      logic kbd;
      logic game;
   } evt_t;
endpackage

// File: rtl/swd_tick.sv
module swd_tick #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SECS_PER_MIN  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic sec_unit,
   output logic unit_tick
);
   localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam int MW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
   localparam logic [PW-1:0] P_LAST = PW'(TICKS_PER_SEC - 1);
   localparam logic [MW-1:0] M_LAST = MW'(SECS_PER_MIN - 1);

   logic [PW-1:0] pre_q;
   logic [MW-1:0] min_q;
   logic          sec_tick;

   assign sec_tick  = run && (pre_q == P_LAST);
   assign unit_tick = sec_unit ? sec_tick : (sec_tick && (min_q == M_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         min_q <= '0;
      end else if (restart || !run) begin
         pre_q <= '0;
         min_q <= '0;
      end else begin
         pre_q <= sec_tick ? '0 : pre_q + 1'b1;
         if (sec_tick)
            min_q <= (min_q == M_LAST) ? '0 : min_q + 1'b1;
      end
   end
endmodule

// File: rtl/swd_evt.sv
module swd_evt import swd_pkg::*; #(
   parameter int IR_DELAY_CYC = 164
) (
   input  logic clk,
   input  logic rst_n,
   input  evt_t ev,
   input  evt_t en,
   output logic reload
);
   logic direct_hit;
   logic ir_hit;

   assign direct_hit = (ev.mouse & en.mouse) | (ev.kbd & en.kbd) | (ev.game & en.game);

   generate
      if (IR_DELAY_CYC == 0) begin : g_ir_now
         assign ir_hit = ev.ir & en.ir;
      end else begin : g_ir_late
         localparam int DW = $clog2(IR_DELAY_CYC + 1);
         logic [DW-1:0] dly_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dly_q <= '0;
            else if (ev.ir && en.ir)
               dly_q <= DW'(IR_DELAY_CYC);
            else if (dly_q != '0)
               dly_q <= dly_q - 1'b1;
         end
         assign ir_hit = (dly_q == DW'(1));
      end
   endgenerate

   assign reload = direct_hit | ir_hit;
endmodule

// File: rtl/swd_count.sv
module swd_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             unit_tick,
   input  logic             force_exp,
   output logic             running,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic reload_now;
   assign reload_now = running && reload;
   assign expire = !load && (force_exp ||
                   (running && !reload_now && unit_tick && count == ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         count   <= '0;
      end else if (load) begin
         count   <= load_val;
         running <= (load_val != '0);
      end else if (force_exp) begin
         count   <= '0;
         running <= 1'b0;
      end else if (reload_now) begin
         count   <= reload_val;
      end else if (running && unit_tick) begin
         count <= count - 1'b1;
         if (count == ONE)
            running <= 1'b0;
      end
   end
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog import swd_pkg::*; #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SECS_PER_MIN  = 60,
   parameter int IR_DELAY_CYC  = 164
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       ev_ir,
   input  logic       ev_mouse,
   input  logic       ev_kbd,
   input  logic       ev_game,
   output logic       kbd_rst_o,
   output logic       pg_drop_o,
   output logic       irq_o,
   output logic [3:0] irq_sel_o
);
   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (TICKS_PER_SEC < 1) begin : g_bad_tps
         $error("TICKS_PER_SEC must be at least 1");
      end
      if (SECS_PER_MIN < 2) begin : g_bad_min
         $error("SECS_PER_MIN must be at least 2");
      end
      if (IR_DELAY_CYC < 0) begin : g_bad_ir
         $error("IR_DELAY_CYC must not be negative");
      end
   endgenerate

   logic             ctrl_wr, cfg_wr, lo_wr, hi_wr, load, force_exp;
   logic [3:0]       en_q;
   logic             status_q;
   logic [7:0]       cfg_q;
   logic [CNT_W-1:0] val_q, val_nx, cnt_w;
   logic             run_w, unit_tick, reload, expire;
   logic             kbd_q, pg_q;
   evt_t             ev_in;

   assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
   assign cfg_wr    = reg_wr && (reg_addr == A_CFG);
   assign lo_wr     = reg_wr && (reg_addr == A_VLO);
   assign hi_wr     = reg_wr && (reg_addr == A_VHI);
   assign load      = lo_wr || hi_wr;
   assign force_exp = ctrl_wr && reg_wdata[C_FORCE];

   always_comb begin
      val_nx = val_q;
      if (lo_wr) val_nx[BYTE_W-1:0]     = reg_wdata;
      if (hi_wr) val_nx[CNT_W-1:BYTE_W] = reg_wdata;
   end

   assign ev_in = '{ir: ev_ir, mouse: ev_mouse, kbd: ev_kbd, game: ev_game};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         cfg_q    <= '0;
         val_q    <= '0;
         status_q <= 1'b0;
         kbd_q    <= 1'b0;
         pg_q     <= 1'b0;
      end else begin
         val_q <= val_nx;
         if (ctrl_wr) en_q <= reg_wdata[7:C_EN_LO];
         if (cfg_wr) cfg_q <= reg_wdata;
         if (expire)
            status_q <= 1'b1;
         else if (ctrl_wr && (reg_wdata[C_STAT] || reg_wdata == 8'h00))
            status_q <= 1'b0;
         kbd_q <= expire && cfg_q[F_KRST];
         pg_q  <= expire && cfg_q[F_PG];
      end
   end

   swd_tick #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run_w),
      .restart(load || (run_w && reload)),
      .sec_unit(cfg_q[F_SEC]), .unit_tick(unit_tick));

   swd_evt #(.IR_DELAY_CYC(IR_DELAY_CYC)) u_evt (
      .clk(clk), .rst_n(rst_n), .ev(ev_in), .en(evt_t'(en_q)), .reload(reload));

   swd_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(val_nx),
      .reload(reload), .reload_val(val_q), .unit_tick(unit_tick),
      .force_exp(force_exp), .running(run_w), .count(cnt_w), .expire(expire));

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = {en_q, 3'b000, status_q};
         A_CFG:   reg_rdata = cfg_q;
         A_VLO:   reg_rdata = val_q[BYTE_W-1:0];
         A_VHI:   reg_rdata = val_q[CNT_W-1:BYTE_W];
         default: reg_rdata = 8'h00;
      endcase
   end

   assign kbd_rst_o = kbd_q;
   assign pg_drop_o = pg_q;
   assign irq_o     = status_q && cfg_q[F_IRQ];
   assign irq_sel_o = cfg_q[3:0];
endmodule

// File: rtl/swd_chk.sv
module swd_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        status,
   input logic        running,
   input logic [15:0] count,
   input logic [15:0] val,
   input logic        kbd,
   input logic        pg,
   input logic        irq,
   input logic        ctrl_wr
);
   p_kbd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      kbd |=> !kbd);
   p_pg_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pg |=> !pg);
   p_kbd_after_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      kbd |-> status);
   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status);
   p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !ctrl_wr) |=> status);
   p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (count != 16'd0 && count <= val));
   p_stop_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> !running);
endmodule

bind sec_watchdog swd_chk u_chk (
   .clk(clk), .rst_n(rst_n), .status(status_q), .running(run_w),
   .count(cnt_w), .val(val_q), .kbd(kbd_rst_o), .pg(pg_drop_o),
   .irq(irq_o), .ctrl_wr(ctrl_wr));

// File: tb/sec_watchdog_bench.sv
`timescale 1ns/1ps
module sec_watchdog_bench;
   localparam int TPS = 4;
   localparam int IRD = 3;
   localparam logic [7:0] A_CTRL = 8'h71, A_CFG = 8'h72, A_VLO = 8'h73, A_VHI = 8'h74;
   localparam int NVEC = 5;
   // {timeout, config}
   localparam logic [23:0] VEC [NVEC] = '{
      {16'd3, 8'hC0}, {16'd1, 8'h90}, {16'h0102, 8'hD5},
      {16'd2, 8'h60}, {16'd7, 8'hA9}};

   logic clk = 0, rst_n = 0;
   logic reg_wr = 0;
   logic [7:0] reg_addr = A_CTRL, reg_wdata = 0, reg_rdata;
   logic ev_ir = 0, ev_mouse = 0, ev_kbd = 0, ev_game = 0;
   logic kbd_rst_o, pg_drop_o, irq_o;
   logic [3:0] irq_sel_o;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   sec_watchdog #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(60), .IR_DELAY_CYC(IRD)) u_sec_watchdog (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_ir(ev_ir),
      .ev_mouse(ev_mouse), .ev_kbd(ev_kbd), .ev_game(ev_game),
      .kbd_rst_o(kbd_rst_o), .pg_drop_o(pg_drop_o), .irq_o(irq_o),
      .irq_sel_o(irq_sel_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0; reg_addr = A_CTRL;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.5 d = reg_rdata;
      reg_addr = A_CTRL;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      case (which)
         0: ev_game = 1;
         1: ev_kbd = 1;
         2: ev_mouse = 1;
         default: ev_ir = 1;
      endcase
      @(negedge clk);
      ev_game = 0; ev_kbd = 0; ev_mouse = 0; ev_ir = 0;
   endtask

   task automatic flag(input string req, input logic exp);
      logic [7:0] d;
      rd(A_CTRL, d);
      check(req, d[0], exp);
   endtask

   task automatic load(input logic [15:0] v);
      wr(A_VHI, v[15:8]);
      wr(A_VLO, v[7:0]);
   endtask

   // R8: event 'which' with control enables 'ctl'; expiry measured from the pulse if enabled
   task automatic evt_case(input string req, input logic [7:0] ctl, input int which, input bit en);
      wr(A_CTRL, ctl | 8'h01);
      wr(A_CFG, 8'h80);
      load(16'd3);
      waitn(3);
      pulse(which);
      if (en) begin
         waitn(11); flag(req, 1'b0);
         waitn(1);  flag(req, 1'b1);
      end else begin
         waitn(7);  flag(req, 1'b0);
         waitn(1);  flag(req, 1'b1);
      end
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(A_CTRL, d); check("R1 ctrl", d, 8'h00);
      rd(A_CFG, d);  check("R1 cfg", d, 8'h00);
      rd(A_VLO, d);  check("R1 vlo", d, 8'h00);
      rd(A_VHI, d);  check("R1 vhi", d, 8'h00);
      check("R1 outputs", {kbd_rst_o, pg_drop_o, irq_o}, 3'b000);
      // R2 control readback
      wr(A_CTRL, 8'hFC);
      rd(A_CTRL, d); check("R2 ctrl readback", d, 8'hF0);
      wr(A_CTRL, 8'h01);
      rd(A_CTRL, d); check("R2 ctrl clear", d, 8'h00);

      // table walk: R3 R4 R5 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         logic [15:0] v;
         logic [7:0] c;
         int n;
         v = VEC[i][23:8];
         c = VEC[i][7:0];
         n = int'(v) * TPS * (c[7] ? 1 : 60);
         wr(A_CTRL, 8'h01);
         wr(A_CFG, c);
         rd(A_CFG, d); check("R2 cfg readback", d, c);
         load(v);
         rd(A_VLO, d); check("R2 vlo readback", d, v[7:0]);
         rd(A_VHI, d); check("R2 vhi readback", d, v[15:8]);
         waitn(n - 1);
         flag(c[7] ? "R3 early" : "R4 early", 1'b0);
         check("R6 no early pulse", {kbd_rst_o, pg_drop_o}, 2'b00);
         waitn(1);
         flag(c[7] ? "R3 expiry" : "R4 expiry", 1'b1);
         check("R6 kbd", kbd_rst_o, c[6]);
         check("R6 pg", pg_drop_o, c[4]);
         check("R7 irq", irq_o, c[5]);
         check("R7 irq line", irq_sel_o, c[3:0]);
         waitn(1);
         check("R6 pulse width", {kbd_rst_o, pg_drop_o}, 2'b00);
         waitn(20);
         flag("R5 sticky", 1'b1);
      end

      // R8 events
      evt_case("R8 mouse disabled", 8'h10, 2, 0);
      evt_case("R8 game enabled", 8'h10, 0, 1);
      evt_case("R8 kbd enabled", 8'h20, 1, 1);
      evt_case("R8 mouse enabled", 8'h40, 2, 1);
      evt_case("R8 game disabled", 8'hE0, 0, 0);

      // R9 infrared delayed reload
      wr(A_CTRL, 8'h81);
      wr(A_CFG, 8'h80);
      load(16'd3);
      waitn(2);
      pulse(3);
      waitn(14); flag("R9 ir early", 1'b0);
      waitn(1);  flag("R9 ir expiry", 1'b1);

      // R10 force
      wr(A_CTRL, 8'h01);
      wr(A_CFG, 8'h50);
      flag("R10 pre", 1'b0);
      wr(A_CTRL, 8'h02);
      rd(A_CTRL, d); check("R10 forced flag", d, 8'h01);
      check("R10 pulses", {kbd_rst_o, pg_drop_o}, 2'b11);

      // R11 clear rules
      wr(A_CTRL, 8'h10);
      rd(A_CTRL, d); check("R11 keep", d, 8'h11);
      wr(A_CTRL, 8'h01);
      flag("R11 clear by bit0", 1'b0);
      wr(A_CTRL, 8'h02);
      flag("R11 force again", 1'b1);
      wr(A_CTRL, 8'h00);
      flag("R11 clear by zero", 1'b0);

      // R12 rewrite while running, then stop
      wr(A_CFG, 8'h80);
      load(16'd5);
      waitn(10);
      wr(A_VLO, 8'd2);
      waitn(7); flag("R12 rewrite early", 1'b0);
      waitn(1); flag("R12 rewrite expiry", 1'b1);
      wr(A_CTRL, 8'h01);
      load(16'd4);
      waitn(5);
      wr(A_VLO, 8'd0);
      waitn(40);
      flag("R12 stopped", 1'b0);
      check("R12 no pulse", {kbd_rst_o, pg_drop_o}, 2'b00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule